// File: doc/BRIEF.md
# Consecutive-Cycle Digital Lock Detector

This block watches the up and down pulses of a phase-frequency detector and sets an active-high lock flag once the loop is settled. A fast sampling clock measures each comparison cycle's phase error. The error is the number of sampling-clock edges at which either pulse is high. A one-cycle strobe marks the end of each reference cycle. The strobe is given after both pulses have returned low, and at the strobe the measured error is put into one of three classes: small, mid or large.

Lock asserts after a run of consecutive small-error cycles. A mode input selects a run of three or of five. Once lock is set, it drops only on a cycle whose error is above a second, looser limit. This gives the detector hysteresis. Both limits are inputs given in sampling-clock counts, so software-free integration only has to tie them to constants that match the clock ratio.

Top module: `phase_lock_detector`

## Requirements
- R1: Reset (active-low `rst_n`) clears the lock flag and the run of small-error cycles, so after reset a full run is needed again.
- R2: With `long_run_i` = 0, `lock_o` rises at the strobe of the third consecutive small cycle and not earlier.
- R3: With `long_run_i` = 1, `lock_o` rises at the strobe of the fifth consecutive small cycle and not earlier.
- R4: While locked, a cycle whose error is greater than `loose_lim_i` clears `lock_o` at that cycle's strobe.
- R5: While locked, a small or mid cycle leaves `lock_o` high.
- R6: While unlocked, a mid or large cycle restarts the run count from zero.
- R7: The error of a cycle is the count of sampling-clock edges since the previous strobe at which `up_i` OR `dn_i` was high. Up-only, down-only and overlapping pulses are measured alike.
- R8: The error count saturates at 2^CNT_W-1 and does not wrap.
- R9: `lock_o` changes only at a clock edge where `cycle_stb_i` is high.
- R10: An error equal to `tight_lim_i` is not small. An error equal to `loose_lim_i` is not large. Small means error < `tight_lim_i`, and large means error > `loose_lim_i`.
- R11: The run length is taken from the mode bit at each strobe. If the mode is lowered after a run has already reached the shorter length, the next small cycle locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_i | input | 1 | Detector up pulse, synchronous to clk |
| dn_i | input | 1 | Detector down pulse, synchronous to clk |
| cycle_stb_i | input | 1 | One-cycle end-of-reference-cycle strobe |
| long_run_i | input | 1 | 0: run of three, 1: run of five |
| tight_lim_i | input | CNT_W | Small-error limit in clk counts |
| loose_lim_i | input | CNT_W | Large-error limit in clk counts |
| lock_o | output | 1 | Lock flag, active high |

## Verification
The error counter adds one at each edge where a pulse is high. At the strobe edge, the count is classified and the lock register is written. As a result, `lock_o` shows a cycle's verdict one edge after the strobe is driven. The bench drives inputs on falling edges and drives the strobe for one cycle. It samples `lock_o` at the next falling edge, which is right after the single register has updated. It also samples `lock_o` at the falling edge just before each strobe, to confirm that the flag held still while the pulses were measured.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

    typedef enum logic [1:0] {
        ERR_SMALL = 2'd0,
        ERR_MID   = 2'd1,
        ERR_LARGE = 2'd2
    } err_cls_e;

endpackage

// File: rtl/lkd_width_meter.sv
module lkd_width_meter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_i,
    input  logic             dn_i,
    input  logic             stb_i,
    output logic [CNT_W-1:0] width_o
);
    localparam logic [CNT_W-1:0] SAT_VAL = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } meter_st_t;

    meter_st_t st_d, st_q;
    logic      pulse;

    assign pulse = up_i | dn_i;

    always_comb begin
        st_d = st_q;
        if (stb_i) begin
            // a new reference cycle starts; count this edge if already high
            st_d.cnt = {{(CNT_W-1){1'b0}}, pulse};
        end else if (pulse && (st_q.cnt != SAT_VAL)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign width_o = st_q.cnt;

    AST_WIDTH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && !pulse) |=> (width_o == '0)); // R7

    AST_WIDTH_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> (width_o >= $past(width_o))); // R8

endmodule

// File: rtl/lkd_classifier.sv
module lkd_classifier
    import lkd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] width_i,
    input  logic [CNT_W-1:0] tight_lim_i,
    input  logic [CNT_W-1:0] loose_lim_i,
    output err_cls_e         cls_o
);
    always_comb begin
        if (width_i < tight_lim_i) begin
            cls_o = ERR_SMALL;
        end else if (width_i > loose_lim_i) begin
            cls_o = ERR_LARGE;
        end else begin
            cls_o = ERR_MID;
        end
    end

endmodule

// File: rtl/lkd_run_judge.sv
module lkd_run_judge
    import lkd_pkg::*;
#(
    parameter int SHORT_RUN = 3,
    parameter int LONG_RUN  = 5
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     stb_i,
    input  logic     long_run_i,
    input  err_cls_e cls_i,
    output logic     lock_o
);
    localparam int RUN_W = $clog2(LONG_RUN + 1);

    typedef struct packed {
        logic             lock;
        logic [RUN_W-1:0] run;
    } judge_st_t;

    judge_st_t      st_d, st_q;
    logic [RUN_W:0] need;
    logic [RUN_W:0] run_inc;

    always_comb begin
        st_d    = st_q;
        need    = long_run_i ? (RUN_W+1)'(LONG_RUN) : (RUN_W+1)'(SHORT_RUN);
        run_inc = {1'b0, st_q.run} + 1'b1;
        if (stb_i) begin
            if (st_q.lock) begin
                if (cls_i == ERR_LARGE) begin
                    st_d.lock = 1'b0;
                    st_d.run  = '0;
                end
            end else if (cls_i == ERR_SMALL) begin
                if (run_inc >= need) begin
                    st_d.lock = 1'b1;
                    st_d.run  = '0;
                end else begin
                    st_d.run = run_inc[RUN_W-1:0];
                end
            end else begin
                st_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_o = st_q.lock;

    AST_RISE_ON_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(stb_i && (cls_i == ERR_SMALL))); // R2

    AST_FALL_ON_LARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_o) |-> $past(stb_i && (cls_i == ERR_LARGE))); // R4

    AST_HOLD_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(lock_o)); // R9

    AST_RUN_BELOW_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run < RUN_W'(LONG_RUN)); // R3

    AST_RUN_IDLE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> (st_q.run == '0)); // R6

endmodule

// File: rtl/phase_lock_detector.sv
module phase_lock_detector
    import lkd_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int SHORT_RUN = 3,
    parameter int LONG_RUN  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_i,
    input  logic             dn_i,
    input  logic             cycle_stb_i,
    input  logic             long_run_i,
    input  logic [CNT_W-1:0] tight_lim_i,
    input  logic [CNT_W-1:0] loose_lim_i,
    output logic             lock_o
);
    logic [CNT_W-1:0] width;
    err_cls_e         cls;

    lkd_width_meter #(.CNT_W(CNT_W)) i_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_i    (up_i),
        .dn_i    (dn_i),
        .stb_i   (cycle_stb_i),
        .width_o (width)
    );

    lkd_classifier #(.CNT_W(CNT_W)) i_classifier (
        .width_i     (width),
        .tight_lim_i (tight_lim_i),
        .loose_lim_i (loose_lim_i),
        .cls_o       (cls)
    );

    lkd_run_judge #(.SHORT_RUN(SHORT_RUN), .LONG_RUN(LONG_RUN)) i_judge (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_i      (cycle_stb_i),
        .long_run_i (long_run_i),
        .cls_i      (cls),
        .lock_o     (lock_o)
    );

endmodule

// File: tb/test_phase_lock_detector.sv
`timescale 1ns/1ps
module test_phase_lock_detector;
    localparam int CNT_W = 6;
    localparam int SAT   = (1 << CNT_W) - 1;
    localparam int TIGHT = 6;
    localparam int LOOSE = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             up = 1'b0, dn = 1'b0, stb = 1'b0, mode = 1'b0;
    logic [CNT_W-1:0] tight = CNT_W'(TIGHT);
    logic [CNT_W-1:0] loose = CNT_W'(LOOSE);
    logic             lock;

    int total = 0, bad = 0;
    bit done = 0;
    bit m_lock = 0;
    int m_run = 0;

    always #2.5 clk = ~clk;

    phase_lock_detector #(.CNT_W(CNT_W), .SHORT_RUN(3), .LONG_RUN(5)) i_phase_lock_detector (
        .clk(clk), .rst_n(rst_n), .up_i(up), .dn_i(dn), .cycle_stb_i(stb),
        .long_run_i(mode), .tight_lim_i(tight), .loose_lim_i(loose), .lock_o(lock)
    );

    task automatic check(input bit got, input bit exp, input string req);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: lock_o=%0b expected=%0b", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        up = 0; dn = 0; stb = 0;
        m_lock = 0; m_run = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // kind 0: up only, 1: down only, 2: overlapping up then down
    task automatic ref_cycle(input int w, input int kind, input string req);
        int m, need;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            up = (kind == 0) || (kind == 2 && i < (2 * w) / 3);
            dn = (kind == 1) || (kind == 2 && i >= w / 3);
        end
        @(negedge clk);
        up = 0; dn = 0;
        check(lock, m_lock, "R9");
        @(negedge clk);
        stb = 1'b1;
        @(negedge clk);
        stb = 1'b0;
        m = (w > SAT) ? SAT : w;
        need = mode ? 5 : 3;
        if (m_lock) begin
            if (m > LOOSE) begin m_lock = 0; m_run = 0; end
        end else if (m < TIGHT) begin
            if (m_run + 1 >= need) begin m_lock = 1; m_run = 0; end
            else m_run++;
        end else begin
            m_run = 0;
        end
        check(lock, m_lock, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        check(lock, 1'b0, "R1");

        // R2: three small cycles in short mode
        mode = 0;
        ref_cycle(2, 0, "R2"); ref_cycle(3, 1, "R2"); ref_cycle(5, 2, "R2");
        // R5 / R10: mid at both boundaries keep lock
        ref_cycle(TIGHT, 0, "R10"); ref_cycle(LOOSE, 2, "R10"); ref_cycle(1, 1, "R5");
        // R4: just above loose drops lock
        ref_cycle(LOOSE + 1, 1, "R4");

        // R3: five small cycles in long mode
        mode = 1;
        for (int k = 0; k < 5; k++) ref_cycle(k, k % 3, "R3");
        ref_cycle(LOOSE + 3, 0, "R4");

        // R6: mid cycle restarts the run
        mode = 0;
        ref_cycle(1, 0, "R6"); ref_cycle(2, 1, "R6"); ref_cycle(TIGHT, 2, "R6");
        ref_cycle(1, 0, "R6"); ref_cycle(1, 1, "R6"); ref_cycle(1, 2, "R6");
        ref_cycle(20, 0, "R4");
        // R6: large cycle restarts the run too
        ref_cycle(0, 0, "R6"); ref_cycle(0, 0, "R6"); ref_cycle(30, 1, "R6");
        ref_cycle(0, 0, "R6"); ref_cycle(0, 0, "R6"); ref_cycle(0, 0, "R6");

        // R8: 66 edges saturate at 63 (large), a wrapping count would read 2
        ref_cycle(66, 2, "R8");

        // R11: run of three in long mode, then short mode locks on next small
        mode = 1;
        ref_cycle(1, 0, "R11"); ref_cycle(1, 0, "R11"); ref_cycle(1, 0, "R11");
        mode = 0;
        ref_cycle(1, 1, "R11");
        ref_cycle(40, 0, "R4");

        // R1: reset mid-run forces a full new run
        ref_cycle(1, 0, "R1"); ref_cycle(1, 0, "R1");
        do_reset();
        check(lock, 1'b0, "R1");
        ref_cycle(1, 0, "R1"); ref_cycle(1, 0, "R1"); ref_cycle(1, 0, "R1");

        // R7: sweep widths and pulse shapes in both modes
        for (int md = 0; md < 2; md++) begin
            mode = md[0];
            for (int w = 0; w < 16; w++)
                for (int kind = 0; kind < 3; kind++)
                    ref_cycle(w, kind, "R7");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule